// File: doc/BRIEF.md
# Output Fault Protection Manager

This block holds the per-channel fault logic for a bank of sixteen low-side switched outputs. Each cycle it takes the host's commanded on/off state for every channel and the digitized fault indications from the analog front end: a per-channel drain-voltage-high flag, a per-channel overtemperature flag, a per-channel open-load flag and one global supply-overvoltage flag. From these it produces the gate enable mask that actually drives the switches, and the sticky fault bits the host reads back in its status word.

Recovery is configurable. A global bit chooses whether outputs come back by themselves once an overvoltage ends or stay off. A second global bit makes the same choice for overtemperature. A per-channel mask bit disables fast shutdown for loads with a high inrush current, such as lamps, which then rely on thermal shutdown alone. A per-channel enable bit gates open-load reporting, for LED loads. A channel that has latched off is released when the host commands it off and then on again. All interfaces are plain level signals sampled on every clock. No data streams through the block, so it has no handshake and applies no back-pressure.

Top module: `fault_prot_mgr`

## Requirements
- R1: `drv_en[i]` is 1 in the cycle after `cmd_on[i]` is sampled 1 with no blocking condition, and is 0 in the cycle after `cmd_on[i]` is sampled 0.
- R2: While `ovolt` is sampled 1, every bit of `drv_en` is 0 from the next cycle.
- R3: With `ov_resume` = 1, outputs follow `cmd_on` again in the cycle after `ovolt` falls. With `ov_resume` = 0, every channel that was commanded on during the overvoltage stays off until its `cmd_on` bit is sampled 0 and then 1.
- R4: While `otemp[i]` is sampled 1, `drv_en[i]` is 0 from the next cycle.
- R5: With `therm_retry` = 1, channel i resumes one cycle after `otemp[i]` falls. With `therm_retry` = 0, it stays off until `cmd_on[i]` goes 0 and then 1.
- R6: With `fast_off_dis[i]` = 0, once `vds_hi[i]` has stayed 1 while the output is on for SHORT_US `us_tick` pulses, the channel is forced off. It stays off until `cmd_on[i]` goes 0 and then 1. A drop of `vds_hi[i]` restarts the count.
- R7: With `fast_off_dis[i]` = 1, `vds_hi[i]` never turns channel i off.
- R8: `fault_flags[i]` becomes 1 in the cycle after any of these is sampled: `vds_hi[i]` while `drv_en[i]` = 1, `otemp[i]`, or `open_ld[i]` with `ol_en[i]` = 1. It then stays 1 until a clear.
- R9: With `ol_en[i]` = 0, `open_ld[i]` leaves `fault_flags[i]` at 0.
- R10: A `flag_clr` pulse zeroes `fault_flags` and `ov_flag` in the following cycle. A fault still present is latched again one cycle later.
- R11: `ov_flag` latches any sampled `ovolt` and is sticky like the channel flags. `any_fault` is 1 whenever `ov_flag` or any bit of `fault_flags` is 1.
- R12: While `rst_n` is 0, `drv_en`, `fault_flags`, `ov_flag` and `any_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cmd_on | input | 16 | Host on/off command per channel |
| ov_resume | input | 1 | 1: resume after overvoltage; 0: latch off |
| therm_retry | input | 1 | 1: retry after cooling; 0: latch off |
| fast_off_dis | input | 16 | Per-channel fast-shutdown disable |
| ol_en | input | 16 | Per-channel open-load report enable |
| vds_hi | input | 16 | Drain voltage above short threshold |
| otemp | input | 16 | Overtemperature flag per channel |
| open_ld | input | 16 | Open-load flag per channel |
| ovolt | input | 1 | Global supply overvoltage |
| flag_clr | input | 1 | Clear strobe for the sticky flags |
| drv_en | output | 16 | Gate enable per channel |
| fault_flags | output | 16 | Sticky fault bit per channel |
| ov_flag | output | 1 | Sticky overvoltage flag |
| any_fault | output | 1 | OR of all sticky flags |

## Verification
The assertions assume the fault inputs are sampled synchronously and are already free of glitches, so that a one-cycle level on `ovolt` or `otemp` is a genuine event. They also assume `us_tick` never stays high for more than one cycle in a row. The stimulus drives every input on the falling edge, generates `us_tick` on alternate cycles, and holds each fault condition for several cycles. The fast-shutdown window is measured with margins of ten cycles on both sides of the expected trip point.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // Static per-channel configuration bits.
  typedef struct packed {
    logic fast_off_dis;
    logic ol_en;
  } ch_cfg_t;

  typedef struct packed {
    logic ov_resume;
    logic therm_retry;
  } glb_cfg_t;
endpackage

// File: rtl/fpm_short_timer.sv
module fpm_short_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // Fires on the tick that completes LIMIT continuous microseconds.
  assign trip = arm && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fpm_channel.sv
module fpm_channel
  import fpm_pkg::*;
#(
  parameter int SHORT_US = 200
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     cmd,
  input  logic     ovolt,
  input  glb_cfg_t gcfg,
  input  ch_cfg_t  cfg,
  input  logic     vds_hi,
  input  logic     otemp,
  input  logic     open_ld,
  output logic     drv_en,
  output logic     fault_set
);
  logic lat_short_q, lat_therm_q, lat_ov_q, drv_q;
  logic lat_short_d, lat_therm_d, lat_ov_d, drv_d;
  logic arm, trip;

  // The timer runs only while the switch conducts into a high drain voltage.
  assign arm = drv_q && vds_hi && !cfg.fast_off_dis;

  fpm_short_timer #(.LIMIT(SHORT_US)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .arm  (arm),
    .trip (trip)
  );

  // Latches hold while commanded on; a zero command releases them.
  always_comb begin
    lat_short_d = cmd && (lat_short_q || trip);
    lat_therm_d = cmd && (lat_therm_q || (otemp && !gcfg.therm_retry));
    lat_ov_d    = cmd && (lat_ov_q || (ovolt && !gcfg.ov_resume));
    drv_d       = cmd && !ovolt && !otemp && !lat_short_d && !lat_therm_d && !lat_ov_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_short_q <= 1'b0;
      lat_therm_q <= 1'b0;
      lat_ov_q    <= 1'b0;
      drv_q       <= 1'b0;
    end else begin
      lat_short_q <= lat_short_d;
      lat_therm_q <= lat_therm_d;
      lat_ov_q    <= lat_ov_d;
      drv_q       <= drv_d;
    end
  end

  assign drv_en    = drv_q;
  assign fault_set = (vds_hi && drv_q) || otemp || (open_ld && cfg.ol_en);
endmodule

// File: rtl/fpm_status.sv
module fpm_status #(
  parameter int N_CH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [N_CH-1:0] ch_set,
  input  logic            ovolt,
  output logic [N_CH-1:0] flags,
  output logic            ov_flag,
  output logic            any_fault
);
  logic [N_CH-1:0] flags_q;
  logic            ov_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      flags_q <= '0;
      ov_q    <= 1'b0;
    end else begin
      flags_q <= flags_q | ch_set;
      ov_q    <= ov_q | ovolt;
    end
  end

  assign flags     = flags_q;
  assign ov_flag   = ov_q;
  assign any_fault = ov_q || (|flags_q);
endmodule

// File: rtl/fault_prot_mgr.sv
module fault_prot_mgr
  import fpm_pkg::*;
#(
  parameter int N_CH     = 16,
  parameter int SHORT_US = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            us_tick,
  input  logic [N_CH-1:0] cmd_on,
  input  logic            ov_resume,
  input  logic            therm_retry,
  input  logic [N_CH-1:0] fast_off_dis,
  input  logic [N_CH-1:0] ol_en,
  input  logic [N_CH-1:0] vds_hi,
  input  logic [N_CH-1:0] otemp,
  input  logic [N_CH-1:0] open_ld,
  input  logic            ovolt,
  input  logic            flag_clr,
  output logic [N_CH-1:0] drv_en,
  output logic [N_CH-1:0] fault_flags,
  output logic            ov_flag,
  output logic            any_fault
);
  glb_cfg_t        gcfg;
  logic [N_CH-1:0] ch_set;

  assign gcfg.ov_resume   = ov_resume;
  assign gcfg.therm_retry = therm_retry;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    ch_cfg_t cfg;
    assign cfg.fast_off_dis = fast_off_dis[i];
    assign cfg.ol_en        = ol_en[i];

    fpm_channel #(.SHORT_US(SHORT_US)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (us_tick),
      .cmd      (cmd_on[i]),
      .ovolt    (ovolt),
      .gcfg     (gcfg),
      .cfg      (cfg),
      .vds_hi   (vds_hi[i]),
      .otemp    (otemp[i]),
      .open_ld  (open_ld[i]),
      .drv_en   (drv_en[i]),
      .fault_set(ch_set[i])
    );
  end

  fpm_status #(.N_CH(N_CH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flag_clr),
    .ch_set   (ch_set),
    .ovolt    (ovolt),
    .flags    (fault_flags),
    .ov_flag  (ov_flag),
    .any_fault(any_fault)
  );
endmodule

// File: rtl/fault_prot_mgr_chk.sv
module fault_prot_mgr_chk #(
  parameter int N_CH = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] cmd_on,
  input logic [N_CH-1:0] otemp,
  input logic            ovolt,
  input logic            flag_clr,
  input logic [N_CH-1:0] drv_en,
  input logic [N_CH-1:0] fault_flags,
  input logic            ov_flag
);
  // R1
  drv_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en & ~$past(cmd_on)) == '0);

  // R2
  ovolt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovolt) |-> (drv_en == '0));

  // R4
  otemp_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en & $past(otemp)) == '0);

  // R8
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_clr) |-> (($past(fault_flags) & ~fault_flags) == '0));

  // R10
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_clr) |-> (fault_flags == '0 && !ov_flag));

  // R11
  ov_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovolt) && !$past(flag_clr)) |-> ov_flag);
endmodule

bind fault_prot_mgr fault_prot_mgr_chk #(.N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_on     (cmd_on),
  .otemp      (otemp),
  .ovolt      (ovolt),
  .flag_clr   (flag_clr),
  .drv_en     (drv_en),
  .fault_flags(fault_flags),
  .ov_flag    (ov_flag)
);

// File: tb/fault_prot_mgr_bench.sv
module fault_prot_mgr_bench;
  localparam int N = 16;
  localparam int LIM = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic [N-1:0] cmd_on = '0, fast_off_dis = '0, ol_en = '0;
  logic [N-1:0] vds_hi = '0, otemp = '0, open_ld = '0;
  logic ov_resume = 1'b1, therm_retry = 1'b1, ovolt = 1'b0, flag_clr = 1'b0;
  logic [N-1:0] drv_en, fault_flags;
  logic ov_flag, any_fault;

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R12";

  always #2.5 clk = ~clk;
  always @(negedge clk) us_tick <= !us_tick;

  fault_prot_mgr #(.N_CH(N), .SHORT_US(LIM)) u_fault_prot_mgr (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cmd_on(cmd_on),
    .ov_resume(ov_resume), .therm_retry(therm_retry), .fast_off_dis(fast_off_dis),
    .ol_en(ol_en), .vds_hi(vds_hi), .otemp(otemp), .open_ld(open_ld),
    .ovolt(ovolt), .flag_clr(flag_clr), .drv_en(drv_en),
    .fault_flags(fault_flags), .ov_flag(ov_flag), .any_fault(any_fault)
  );

  // Behavioural reference, advanced on each rising edge from the inputs.
  bit m_drv[N], m_ls[N], m_lt[N], m_lo[N], m_flt[N];
  int m_cnt[N];
  bit m_ov;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_drv[i] = 0; m_ls[i] = 0; m_lt[i] = 0; m_lo[i] = 0; m_flt[i] = 0; m_cnt[i] = 0;
      end
      m_ov = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit trip, hit;
        trip = 0;
        hit = (vds_hi[i] && m_drv[i]) || otemp[i] || (open_ld[i] && ol_en[i]);
        if (!(m_drv[i] && vds_hi[i] && !fast_off_dis[i])) m_cnt[i] = 0;
        else if (us_tick) begin
          if (m_cnt[i] + 1 >= LIM) trip = 1;
          else m_cnt[i] = m_cnt[i] + 1;
        end
        if (!cmd_on[i]) begin
          m_ls[i] = 0; m_lt[i] = 0; m_lo[i] = 0;
        end else begin
          if (trip) m_ls[i] = 1;
          if (otemp[i] && !therm_retry) m_lt[i] = 1;
          if (ovolt && !ov_resume) m_lo[i] = 1;
        end
        m_flt[i] = flag_clr ? 0 : (m_flt[i] || hit);
        m_drv[i] = cmd_on[i] && !ovolt && !otemp[i] && !m_ls[i] && !m_lt[i] && !m_lo[i];
      end
      m_ov = flag_clr ? 0 : (m_ov || ovolt);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    if (!done) begin
      logic [N-1:0] ed, ef;
      bit any;
      any = m_ov;
      for (int i = 0; i < N; i++) begin
        ed[i] = m_drv[i]; ef[i] = m_flt[i];
        any = any || m_flt[i];
      end
      chk({phase, " drv"}, 32'(drv_en), 32'(ed));
      chk({phase, " flags"}, 32'(fault_flags), 32'(ef));
      chk("R11 ov_flag", 32'(ov_flag), 32'(m_ov));
      chk("R11 any", 32'(any_fault), 32'(any));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags;
    flag_clr = 1; cyc(1); flag_clr = 0; cyc(1);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R12 drv", 32'(drv_en), 0);
    chk("R12 flags", 32'(fault_flags), 0);
    rst_n = 1;
    phase = "R1";
    cmd_on = 16'hFFFF; cyc(2);
    chk("R1 all on", 32'(drv_en), 32'hFFFF);
    cmd_on = 16'h00F0; cyc(2);
    chk("R1 subset", 32'(drv_en), 32'h00F0);

    phase = "R2"; ov_resume = 1; ovolt = 1; cyc(3);
    chk("R2 ov off", 32'(drv_en), 0);
    chk("R11 ov flag", 32'(ov_flag), 1);
    phase = "R3"; ovolt = 0; cyc(2);
    chk("R3 resume", 32'(drv_en), 32'h00F0);
    phase = "R10"; clear_flags();
    chk("R10 ov cleared", 32'(ov_flag), 0);

    phase = "R3"; ov_resume = 0; ovolt = 1; cyc(2); ovolt = 0; cyc(3);
    chk("R3 latched", 32'(drv_en), 0);
    cmd_on[4] = 0; cyc(2); cmd_on[4] = 1; cyc(2);
    chk("R3 toggle", 32'(drv_en), 32'h0010);
    cmd_on = 16'h0000; cyc(2); cmd_on = 16'h07E0; ov_resume = 1; cyc(2);
    clear_flags();

    phase = "R5"; therm_retry = 1; otemp[5] = 1; cyc(3);
    chk("R4 otemp off", 32'(drv_en[5]), 0);
    chk("R8 otemp flag", 32'(fault_flags[5]), 1);
    otemp[5] = 0; cyc(2);
    chk("R5 retry", 32'(drv_en[5]), 1);
    therm_retry = 0; otemp[6] = 1; cyc(2); otemp[6] = 0; cyc(3);
    chk("R5 latched", 32'(drv_en[6]), 0);
    cmd_on[6] = 0; cyc(2); cmd_on[6] = 1; cyc(2);
    chk("R5 toggle", 32'(drv_en[6]), 1);
    therm_retry = 1; clear_flags();

    phase = "R6"; vds_hi[7] = 1; cyc(300); vds_hi[7] = 0; cyc(2);
    chk("R6 restart keeps on", 32'(drv_en[7]), 1);
    chk("R8 short flag", 32'(fault_flags[7]), 1);
    vds_hi[7] = 1; cyc(390);
    chk("R6 before trip", 32'(drv_en[7]), 1);
    cyc(20);
    chk("R6 tripped", 32'(drv_en[7]), 0);
    vds_hi[7] = 0; cyc(3);
    chk("R6 stays off", 32'(drv_en[7]), 0);
    cmd_on[7] = 0; cyc(2); cmd_on[7] = 1; cyc(2);
    chk("R6 toggle", 32'(drv_en[7]), 1);

    phase = "R7"; fast_off_dis[8] = 1; vds_hi[8] = 1; cyc(600);
    chk("R7 no fast off", 32'(drv_en[8]), 1);
    vds_hi[8] = 0; clear_flags();

    phase = "R9"; open_ld[9] = 1; cyc(4);
    chk("R9 gated", 32'(fault_flags[9]), 0);
    ol_en[9] = 1; cyc(2);
    chk("R8 open flag", 32'(fault_flags[9]), 1);
    open_ld[9] = 0; ol_en = 0; cyc(3);
    chk("R8 sticky", 32'(fault_flags[9]), 1);

    phase = "R10"; otemp[10] = 1; cyc(2);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R10 cleared", 32'(fault_flags), 0);
    cyc(1);
    chk("R10 relatch", 32'(fault_flags), 32'h0400);
    otemp[10] = 0; cyc(3);
    finish_run();
  end
endmodule